// File: doc/BRIEF.md
# Dual-Tone Parallel Phase Generator

This block produces the instantaneous phase words for a digital upconverter whose output runs at eight samples per fabric clock (1 GSPS from a 125 MHz clock by default). It serves two tones at once. Both share a coarse centre frequency picked from a grid of quarter-clock steps, and each adds its own signed fine offset. Every clock it presents eight lane phases per tone. Lane 0 is the earliest sample of that clock and lane 7 the latest. A downstream sine/cosine stage turns these phases into samples.

The coarse grid is a multiple of one quarter of the fabric clock, so the coarse per-sample advance is an exact fraction of a cycle with five fractional bits. That part therefore costs only a two-bit counter and a few small adders. The fine offsets are accumulated once per fabric clock. Each lane's position within the clock is then added as a constant multiple of the fine word, at a resolution three bits finer than the output. The frequency step of a fine word is the fabric clock divided by 2^32, about 0.03 Hz.

A user sets a centre with the coarse index. The user then scans one or both fine words around it with the update strobe, leaving the centre where it is. The clear input restarts all phases at zero.

Top module: `dual_tone_phase_gen`

## Requirements
- R1: After reset, and until the first update strobe, every lane of both tone outputs reads zero.
- R2: With both fine words zero and coarse index n (5 bits, unsigned), the lane k output in clock t after a clear is ((8*t + k) * n mod 32) * 2^27, for both tones.
- R3: With coarse index 0 and fine word F (32-bit), the lane k output in clock t after a clear is floor(((8*t + k) * F mod 2^35) / 8).
- R4: In general, the lane k output in clock t after a clear is bits 34..3 of the 35-bit sum (8*t + k) * (n * 2^30 + sext(F)), taken mod 2^35.
- R5: Fine words are two's complement, so a negative word yields a decreasing phase that wraps modulo 2^32.
- R6: Both tones use the same coarse index, and each tone uses only its own fine word (tone A uses ftw_a_i, tone B uses ftw_b_i).
- R7: The coarse index and both fine words are captured only at a clock edge where upd_i is 1. They apply to all eight lanes from the following cycle. Input changes without the strobe leave the outputs unchanged from their prior trajectory.
- R8: A clear at a clock edge zeroes the coarse and both fine accumulators, so that lane 0 of both tones reads zero in the next cycle.
- R9: Phase stays continuous across an update without clear. Lane 0 after the edge equals lane 7 before it plus one sample step of the previous settings, at 35-bit resolution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| upd_i | input | 1 | Capture strobe for coarse index and fine words |
| clr_i | input | 1 | Zeroes all phase accumulators at the edge |
| cidx_i | input | 5 | Coarse index n, centre = n * fclk / 4 |
| ftw_a_i | input | 32 | Signed fine word of tone A, per-clock increment |
| ftw_b_i | input | 32 | Signed fine word of tone B, per-clock increment |
| phase_a_o | output | 256 | Tone A lane phases, lane k in bits [32k+31:32k] |
| phase_b_o | output | 256 | Tone B lane phases, lane k in bits [32k+31:32k] |

## Verification
The hardest state to reach is a retune that lands mid-trajectory, without a clear. The accumulators then hold non-zero phases built from the old settings, and all eight lanes must switch to the new step on the same edge with no gap. The stimulus runs each tone long enough to wrap. It then strobes new coarse and fine values, some of them negative or at the extreme 0x80000000, while the clear is held low. The bench carries its own 35-bit lane-0 phase per tone forward, so every lane of the following cycles is checked against the continuous trajectory.

// File: rtl/dtpg_pkg.sv
`timescale 1ns/1ps
package dtpg_pkg;
  // default geometry: 8 lanes per clock, quarter-clock coarse grid, 32-bit phase
  localparam int DEF_LANES_LG = 3;
  localparam int DEF_GRID_LG  = 2;
  localparam int DEF_PHASE_W  = 32;

  // fractional bits of the exact coarse per-sample advance
  function automatic int coarse_frac_bits(input int lanes_lg, input int grid_lg);
    return lanes_lg + grid_lg;
  endfunction
endpackage

// File: rtl/dtpg_rst_sync.sv
`timescale 1ns/1ps
module dtpg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_q_n <= meta_q;
    end
  end
endmodule

// File: rtl/dtpg_coarse.sv
`timescale 1ns/1ps
module dtpg_coarse #(
  parameter int LANES_LG = dtpg_pkg::DEF_LANES_LG,
  parameter int GRID_LG  = dtpg_pkg::DEF_GRID_LG,
  localparam int LANES   = 1 << LANES_LG,
  localparam int FRAC    = dtpg_pkg::coarse_frac_bits(LANES_LG, GRID_LG)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_i,
  input  logic [FRAC-1:0]       idx_i,
  output logic [LANES*FRAC-1:0] frac_o
);
  // coarse phase at lane 0 is always a multiple of 1/2^GRID_LG cycle,
  // so only the quarter count needs storage
  logic [GRID_LG-1:0] qtr_q, qtr_nxt;

  always_comb begin
    if (clr_i) qtr_nxt = '0;
    else       qtr_nxt = qtr_q + idx_i[GRID_LG-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) qtr_q <= '0;
    else        qtr_q <= qtr_nxt;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [FRAC-1:0] offs;
    always_comb begin
      offs = FRAC'(k) * idx_i;
      frac_o[k*FRAC +: FRAC] = {qtr_q, {LANES_LG{1'b0}}} + offs;
    end
  end

  // R8: clear restarts the coarse lane 0 fraction
  p_coarse_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (frac_o[FRAC-1:0] == '0));
endmodule

// File: rtl/dtpg_fine_acc.sv
`timescale 1ns/1ps
module dtpg_fine_acc #(
  parameter int PHASE_W = dtpg_pkg::DEF_PHASE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic [PHASE_W-1:0] ftw_i,
  output logic [PHASE_W-1:0] acc_o
);
  logic [PHASE_W-1:0] acc_q, acc_nxt;

  always_comb begin
    if (clr_i) acc_nxt = '0;
    else       acc_nxt = acc_q + ftw_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_nxt;
  end

  assign acc_o = acc_q;

  // R8: accumulator is zero the cycle after a clear
  p_fine_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (acc_o == '0));
endmodule

// File: rtl/dtpg_lane_sum.sv
`timescale 1ns/1ps
module dtpg_lane_sum #(
  parameter int PHASE_W  = dtpg_pkg::DEF_PHASE_W,
  parameter int LANES_LG = dtpg_pkg::DEF_LANES_LG,
  parameter int FRAC     = 5,
  localparam int LANES   = 1 << LANES_LG,
  localparam int WW      = PHASE_W + LANES_LG
) (
  input  logic [PHASE_W-1:0]    acc_i,
  input  logic [PHASE_W-1:0]    ftw_i,
  input  logic [LANES*FRAC-1:0] frac_i,
  output logic [LANES*WW-1:0]   wide_o
);
  logic [WW-1:0] ftw_sx;
  logic [WW-1:0] base;

  assign ftw_sx = {{LANES_LG{ftw_i[PHASE_W-1]}}, ftw_i};
  assign base   = {acc_i, {LANES_LG{1'b0}}};

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [WW-1:0] fine_k;
    logic [WW-1:0] coarse_k;
    always_comb begin
      fine_k   = base + WW'(k) * ftw_sx;
      coarse_k = {frac_i[k*FRAC +: FRAC], {(WW-FRAC){1'b0}}};
      wide_o[k*WW +: WW] = fine_k + coarse_k;
    end
  end
endmodule

// File: rtl/dual_tone_phase_gen.sv
`timescale 1ns/1ps
module dual_tone_phase_gen #(
  parameter int PHASE_W  = dtpg_pkg::DEF_PHASE_W,
  parameter int LANES_LG = dtpg_pkg::DEF_LANES_LG,
  parameter int GRID_LG  = dtpg_pkg::DEF_GRID_LG,
  localparam int LANES   = 1 << LANES_LG,
  localparam int FRAC    = dtpg_pkg::coarse_frac_bits(LANES_LG, GRID_LG),
  localparam int WW      = PHASE_W + LANES_LG
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     upd_i,
  input  logic                     clr_i,
  input  logic [FRAC-1:0]          cidx_i,
  input  logic [PHASE_W-1:0]       ftw_a_i,
  input  logic [PHASE_W-1:0]       ftw_b_i,
  output logic [LANES*PHASE_W-1:0] phase_a_o,
  output logic [LANES*PHASE_W-1:0] phase_b_o
);
  logic rst_q_n;

  dtpg_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  // active settings, loaded by the strobe only
  logic [FRAC-1:0]    idx_q, idx_nxt;
  logic [PHASE_W-1:0] fa_q, fa_nxt, fb_q, fb_nxt;

  always_comb begin
    idx_nxt = idx_q;
    fa_nxt  = fa_q;
    fb_nxt  = fb_q;
    if (upd_i) begin
      idx_nxt = cidx_i;
      fa_nxt  = ftw_a_i;
      fb_nxt  = ftw_b_i;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      idx_q <= '0;
      fa_q  <= '0;
      fb_q  <= '0;
    end else begin
      idx_q <= idx_nxt;
      fa_q  <= fa_nxt;
      fb_q  <= fb_nxt;
    end
  end

  logic [LANES*FRAC-1:0] cfrac;

  dtpg_coarse #(.LANES_LG(LANES_LG), .GRID_LG(GRID_LG)) u_coarse (
    .clk(clk), .rst_n(rst_q_n), .clr_i(clr_i), .idx_i(idx_q), .frac_o(cfrac)
  );

  logic [PHASE_W-1:0]  acc_t  [2];
  logic [PHASE_W-1:0]  ftw_t  [2];
  logic [LANES*WW-1:0] wide_t [2];

  assign ftw_t[0] = fa_q;
  assign ftw_t[1] = fb_q;

  for (genvar t = 0; t < 2; t++) begin : g_tone
    dtpg_fine_acc #(.PHASE_W(PHASE_W)) u_acc (
      .clk(clk), .rst_n(rst_q_n), .clr_i(clr_i), .ftw_i(ftw_t[t]), .acc_o(acc_t[t])
    );
    dtpg_lane_sum #(.PHASE_W(PHASE_W), .LANES_LG(LANES_LG), .FRAC(FRAC)) u_sum (
      .acc_i(acc_t[t]), .ftw_i(ftw_t[t]), .frac_i(cfrac), .wide_o(wide_t[t])
    );
    for (genvar k = 0; k < LANES; k++) begin : g_out
      if (t == 0) begin : g_a
        assign phase_a_o[k*PHASE_W +: PHASE_W] = wide_t[t][k*WW+LANES_LG +: PHASE_W];
      end else begin : g_b
        assign phase_b_o[k*PHASE_W +: PHASE_W] = wide_t[t][k*WW+LANES_LG +: PHASE_W];
      end
    end
  end

  // one-sample step of each tone at wide resolution, for the checks below
  logic [WW-1:0] step_a, step_b;
  assign step_a = {idx_q, {(WW-FRAC){1'b0}}} + {{LANES_LG{fa_q[PHASE_W-1]}}, fa_q};
  assign step_b = {idx_q, {(WW-FRAC){1'b0}}} + {{LANES_LG{fb_q[PHASE_W-1]}}, fb_q};

  // R8: after a clear, lane 0 of both tones reads zero
  p_clear_out_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    clr_i |=> (phase_a_o[PHASE_W-1:0] == '0 && phase_b_o[PHASE_W-1:0] == '0));

  // R9: continuity across the clock boundary, whatever the strobe does
  p_cont_a_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    !clr_i |=> (wide_t[0][WW-1:0] == $past(wide_t[0][LANES*WW-1 -: WW] + step_a)));
  p_cont_b_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    !clr_i |=> (wide_t[1][WW-1:0] == $past(wide_t[1][LANES*WW-1 -: WW] + step_b)));

  // R7: lane spacing holds when no strobe was seen
  p_spacing_hold_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    !upd_i |=> ((wide_t[0][2*WW-1 -: WW] - wide_t[0][WW-1:0]) ==
                $past(wide_t[0][2*WW-1 -: WW] - wide_t[0][WW-1:0])));
endmodule

// File: tb/dual_tone_phase_gen_tb.sv
`timescale 1ns/1ps
module dual_tone_phase_gen_tb;
  localparam int CLK_PERIOD = 8;
  localparam int W  = 32;
  localparam int NL = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd = 1'b0, clr = 1'b0;
  logic [4:0] cidx = '0;
  logic [W-1:0] fa = '0, fb = '0;
  logic [NL*W-1:0] pa_o, pb_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_tone_phase_gen u_dut (
    .clk(clk), .rst_n(rst_n), .upd_i(upd), .clr_i(clr), .cidx_i(cidx),
    .ftw_a_i(fa), .ftw_b_i(fb), .phase_a_o(pa_o), .phase_b_o(pb_o)
  );

  // model: 35-bit lane-0 phase per tone and the active settings
  logic [34:0] ma, mb;
  logic [4:0]  mn;
  logic [W-1:0] mfa, mfb;

  function automatic logic [34:0] stepw(input logic [4:0] n, input logic [W-1:0] f);
    return {n, 30'b0} + {{3{f[W-1]}}, f};
  endfunction

  function automatic logic [NL*W-1:0] lanes(input logic [34:0] p, input logic [34:0] s);
    logic [NL*W-1:0] v;
    for (int k = 0; k < NL; k++) begin
      logic [34:0] x;
      x = p + 35'(k) * s;
      v[k*W +: W] = x[34:3];
    end
    return v;
  endfunction

  task automatic cmp(input logic [NL*W-1:0] got, input logic [NL*W-1:0] exp,
                     input string req, input string tone);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      for (int k = 0; k < NL; k++) begin
        if (got[k*W +: W] !== exp[k*W +: W]) begin
          $display("FAIL %s tone %s lane %0d got=%h exp=%h", req, tone, k,
                   got[k*W +: W], exp[k*W +: W]);
          break;
        end
      end
    end
  endtask

  task automatic cyc(input logic u, input logic c, input logic [4:0] n,
                     input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    upd = u; clr = c; cidx = n; fa = a; fb = b;
    @(posedge clk);
    if (c) begin
      ma = '0; mb = '0;
    end else begin
      ma = ma + (stepw(mn, mfa) << 3);
      mb = mb + (stepw(mn, mfb) << 3);
    end
    if (u) begin
      mn = n; mfa = a; mfb = b;
    end
    @(negedge clk);
    cmp(pa_o, lanes(ma, stepw(mn, mfa)), req, "A");
    cmp(pb_o, lanes(mb, stepw(mn, mfb)), req, "B");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] fine_set [7];
    ma = '0; mb = '0; mn = '0; mfa = '0; mfb = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: outputs zero after reset
    cmp(pa_o, '0, "R1", "A");
    cmp(pb_o, '0, "R1", "B");
    cyc(0, 0, 5'd0, '0, '0, "R1");

    // R2: every coarse index, fine words zero
    for (int n = 0; n < 32; n++) begin
      cyc(1, 1, 5'(n), '0, '0, "R2");
      for (int t = 0; t < 4; t++) cyc(0, 0, 5'(n), '0, '0, "R2");
    end

    // R3 positive and R5 negative fine words, coarse zero, tones differ (R6)
    fine_set[0] = 32'h0000_0001; fine_set[1] = 32'h1000_0000;
    fine_set[2] = 32'h7fff_ffff; fine_set[3] = 32'h1234_5679;
    fine_set[4] = 32'hffff_ffff; fine_set[5] = 32'h8000_0000;
    fine_set[6] = 32'hfedc_ba98;
    for (int i = 0; i < 7; i++) begin
      cyc(1, 1, 5'd0, fine_set[i], fine_set[(i+3)%7], (i < 4) ? "R3 R6" : "R5 R6");
      for (int t = 0; t < 6; t++)
        cyc(0, 0, 5'd0, fine_set[i], fine_set[(i+3)%7], (i < 4) ? "R3" : "R5");
    end

    // R4: coarse and fine combined, shared coarse across tones (R6)
    for (int i = 0; i < 6; i++) begin
      logic [4:0] n;
      n = 5'((i * 13 + 1) % 32);
      cyc(1, 1, n, fine_set[i], fine_set[6-i], "R4 R6");
      for (int t = 0; t < 10; t++) cyc(0, 0, n, fine_set[i], fine_set[6-i], "R4");
    end

    // R7: changes without strobe are ignored
    cyc(1, 1, 5'd3, 32'h0100_0000, 32'hff00_0000, "R7");
    cyc(0, 0, 5'd3, 32'h0100_0000, 32'hff00_0000, "R7");
    cyc(0, 0, 5'd17, 32'h5555_5555, 32'h0000_0007, "R7");
    cyc(0, 0, 5'd29, 32'h8000_0000, 32'h7fff_ffff, "R7");
    cyc(0, 0, 5'd29, 32'h8000_0000, 32'h7fff_ffff, "R7");

    // R9: retune mid-run without clear, then again with extremes
    cyc(1, 0, 5'd17, 32'h5555_5555, 32'h0000_0007, "R9");
    for (int t = 0; t < 5; t++) cyc(0, 0, 5'd17, 32'h5555_5555, 32'h0000_0007, "R9");
    cyc(1, 0, 5'd30, 32'h8000_0000, 32'h7fff_ffff, "R9");
    for (int t = 0; t < 5; t++) cyc(0, 0, 5'd30, 32'h8000_0000, 32'h7fff_ffff, "R9");
    cyc(1, 0, 5'd30, 32'h0000_0000, 32'h0abc_def1, "R9");
    cyc(0, 0, 5'd30, 32'h0000_0000, 32'h0abc_def1, "R9");

    // R8: clear mid-run, with and without a simultaneous update
    cyc(0, 1, 5'd30, 32'h0000_0000, 32'h0abc_def1, "R8");
    n_checks++;
    if (pa_o[W-1:0] !== '0 || pb_o[W-1:0] !== '0) begin
      n_fail++;
      $display("FAIL R8 lane0 got a=%h b=%h exp=0", pa_o[W-1:0], pb_o[W-1:0]);
    end
    for (int t = 0; t < 3; t++) cyc(0, 0, 5'd30, '0, '0, "R8");
    cyc(1, 1, 5'd9, 32'hdead_beef, 32'h0000_1000, "R8");
    for (int t = 0; t < 4; t++) cyc(0, 0, 5'd9, 32'hdead_beef, 32'h0000_1000, "R8");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule